// File: doc/BRIEF.md
# Descriptor DMA Run Controller

This block is the run-control sequencer of one descriptor-driven DMA channel. Software writes a control word holding an enable bit, a continue bit and a continue-from-start bit. The block then walks descriptors. It keeps 64-bit current pointers for the source and destination descriptor chains and requests descriptor fetches, payload transfers and next-pointer reads over request/done handshakes. It reports a 2-bit channel state. Memory access, data movement and interrupt registers sit outside the block. The block only gives one-cycle event pulses for pause, error and descriptor interrupt requests.

Two pointer modes exist. In register mode a single descriptor held in registers is run, and the channel then disables itself. In memory mode descriptors are fetched from memory. Each descriptor carries a command field: stop, halt or continue. When a descriptor completes with no stop or halt, the source pointer moves on. In linear layout the next descriptor sits 16 bytes further on. In linked layout a 64-bit next pointer is read from the current pointer plus 16. A halted channel can later be resumed past the halted descriptor, or restarted from the programmed start addresses.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset the block is in this condition: state_o is 0, en_o is 0, no request output is high, and both pointer outputs are 0.
- R2: state_o encodes the channel state as 0 for disabled, 1 for running and 2 for paused. While the error flag is set, state_o reads 3.
- R3: An accepted control write with enable set does the following unless it is a resume. It clears the error flag and loads both pointers from src_start_i and dst_start_i. In memory mode (ptr_mem_i=1) it first fetches the destination descriptor (fetch_sel_o=1, at the destination pointer) and then the source descriptor (fetch_sel_o=0, at the source pointer).
- R4: xfer_req_o rises only after a source descriptor fetch has completed or after a register-mode start. The descriptor command is acted on only after xfer_done_i. At most one of the three request outputs is high at a time.
- R5: In register mode (ptr_mem_i=0) no descriptor fetch is made and exactly one transfer is requested. The channel then clears en_o and returns to state 0.
- R6: A descriptor with command 2 (stop) ends the run when its transfer finishes: en_o clears and state_o becomes 0.
- R7: A descriptor with command 1 (halt) sets state_o to 2 when its transfer finishes, and pause_evt_o pulses for one cycle. en_o stays 1.
- R8: A descriptor with command 0 or 3 and type 0 (linear) advances the source pointer by 16 and fetches the next source descriptor there.
- R9: A descriptor with command 0 or 3 and type 1 (linked) issues a next-pointer read at the source pointer plus 16. The value returned on link_ptr_i becomes the new source pointer.
- R10: A descriptor pointer whose low 4 bits are not zero is handled as an error. No fetch is requested at that pointer, err_evt_o pulses once, and state_o reads 3 until the next enabling write.
- R11: An enabling write while paused with continue=1 resumes the channel. With continue-from-start=0 the source pointer advances past the halted descriptor according to that descriptor's type, and no destination fetch is made. With continue-from-start=1 both pointers reload from the start inputs and the destination descriptor is fetched again.
- R12: A write with enable cleared while paused moves the channel to state 0 if continue=1. It leaves the channel paused if continue=0.
- R13: A control write while the channel is running is ignored. en_o and state_o are unchanged.
- R14: desc_irq_o pulses for one cycle when a descriptor whose interrupt-request bit is set finishes its transfer. In memory mode the bit is fetch_intr_i; in register mode it is reg_intr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_en_i | input | 1 | Enable bit of the control write |
| ctl_cont_i | input | 1 | Continue bit of the control write |
| ctl_cont_start_i | input | 1 | Continue-from-start bit of the control write |
| ptr_mem_i | input | 1 | Pointer mode: 1 memory descriptors, 0 register descriptor |
| reg_intr_i | input | 1 | Interrupt-request bit of the register-held descriptor |
| src_start_i | input | ADDR_W | Programmed source descriptor start address |
| dst_start_i | input | ADDR_W | Programmed destination descriptor start address |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_sel_o | output | 1 | Fetch target: 1 destination, 0 source |
| fetch_addr_o | output | ADDR_W | Descriptor fetch address |
| fetch_done_i | input | 1 | Descriptor fetch completed |
| fetch_cmd_i | input | 2 | Command of fetched descriptor (1 halt, 2 stop) |
| fetch_linked_i | input | 1 | Type of fetched descriptor (1 linked) |
| fetch_intr_i | input | 1 | Interrupt-request bit of fetched descriptor |
| xfer_req_o | output | 1 | Payload transfer request |
| xfer_done_i | input | 1 | Payload transfer completed |
| link_req_o | output | 1 | Next-pointer read request |
| link_addr_o | output | ADDR_W | Next-pointer read address |
| link_done_i | input | 1 | Next-pointer read completed |
| link_ptr_i | input | ADDR_W | Next-pointer value read |
| state_o | output | 2 | Channel state |
| en_o | output | 1 | Current enable bit |
| src_ptr_o | output | ADDR_W | Current source descriptor pointer |
| dst_ptr_o | output | ADDR_W | Current destination descriptor pointer |
| pause_evt_o | output | 1 | Pause event pulse |
| err_evt_o | output | 1 | Error event pulse |
| desc_irq_o | output | 1 | Descriptor interrupt event pulse |

## Verification
Every cycle, the assertions check four things. At most one request is high. A transfer request rises only after a source fetch completes or a register-mode start. A stalled fetch phase leads to state 3 with an error pulse. Stop, halt, register-mode completion, busy-time writes and linear advance each reach the right next state. Other behaviours need whole scenarios, so only the bench can show them. These are the order of destination and source fetches after a start, the distinct pointer values reached through linked reads, resume past a halted descriptor versus restart from the start addresses, and the paused-then-disabled sequence.

// File: rtl/dma_run_pkg.sv
package dma_run_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2,
        ST_FAULT = 2'd3
    } chan_state_e;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_DST_FETCH = 3'd1,
        PH_SRC_FETCH = 3'd2,
        PH_XFER      = 3'd3,
        PH_LINK      = 3'd4
    } phase_e;

    localparam logic [1:0] CMD_HALT = 2'd1;
    localparam logic [1:0] CMD_STOP = 2'd2;

    // Control fields captured from a fetched source descriptor
    typedef struct packed {
        logic [1:0] cmd;
        logic       linked;
        logic       intr;
    } desc_ctl_t;

    // Pointer update operations, at most one per cycle
    typedef struct packed {
        logic ld_start;
        logic adv_lin;
        logic ld_link;
    } ptr_op_t;

    function automatic chan_state_e report_state(phase_e ph, logic parked, logic err);
        if (err)
            return ST_FAULT;
        else if (ph != PH_IDLE)
            return ST_RUN;
        else if (parked)
            return ST_PAUSE;
        return ST_OFF;
    endfunction

endpackage

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs
    import dma_run_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_op_t           op,
    input  logic [ADDR_W-1:0] src_start_i,
    input  logic [ADDR_W-1:0] dst_start_i,
    input  logic [ADDR_W-1:0] link_ptr_i,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [ADDR_W-1:0] link_addr_o,
    output logic              src_ok_o,
    output logic              dst_ok_o
);
    localparam int              ALIGN_W = $clog2(DESC_BYTES);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DESC_BYTES);

    logic [ADDR_W-1:0] src_q, dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (op.ld_start) begin
            src_q <= src_start_i;
            dst_q <= dst_start_i;
        end else if (op.adv_lin) begin
            src_q <= src_q + STEP;
        end else if (op.ld_link) begin
            src_q <= link_ptr_i;
        end
    end

    assign src_o       = src_q;
    assign dst_o       = dst_q;
    assign link_addr_o = src_q + STEP;
    assign src_ok_o    = (src_q[ALIGN_W-1:0] == '0);
    assign dst_ok_o    = (dst_q[ALIGN_W-1:0] == '0);

    // R4: the sequencer never asks for two pointer updates at once
    p_one_op_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op.ld_start, op.adv_lin, op.ld_link}));

    // R8: a linear advance moves the source pointer by one descriptor
    p_lin_step_r8: assert property (@(posedge clk) disable iff (rst)
        op.adv_lin |=> (src_q == $past(src_q) + STEP));

endmodule

// File: rtl/dma_run_seq.sv
module dma_run_seq
    import dma_run_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr_i,
    input  logic      ctl_en_i,
    input  logic      ctl_cont_i,
    input  logic      ctl_cont_start_i,
    input  logic      ptr_mem_i,
    input  logic      reg_intr_i,
    input  logic      fetch_done_i,
    input  desc_ctl_t fetch_ctl_i,
    input  logic      xfer_done_i,
    input  logic      link_done_i,
    input  logic      src_ok_i,
    input  logic      dst_ok_i,
    output phase_e    ph_o,
    output logic      parked_o,
    output logic      err_o,
    output logic      en_o,
    output logic      pause_evt_o,
    output logic      err_evt_o,
    output logic      irq_evt_o,
    output ptr_op_t   op_o
);
    phase_e    ph_q, ph_n;
    logic      parked_q, parked_n;
    logic      err_q, err_n;
    logic      en_q, en_n;
    logic      mode_q, mode_n;
    desc_ctl_t dctl_q, dctl_n;
    logic      pause_q, pause_n;
    logic      errp_q, errp_n;
    logic      irq_q, irq_n;
    ptr_op_t   op;

    always_comb begin
        ph_n     = ph_q;
        parked_n = parked_q;
        err_n    = err_q;
        en_n     = en_q;
        mode_n   = mode_q;
        dctl_n   = dctl_q;
        pause_n  = 1'b0;
        errp_n   = 1'b0;
        irq_n    = 1'b0;
        op       = '0;
        case (ph_q)
            PH_IDLE: begin
                if (ctl_wr_i) begin
                    en_n = ctl_en_i;
                    if (ctl_en_i) begin
                        err_n    = 1'b0;
                        parked_n = 1'b0;
                        mode_n   = ptr_mem_i;
                        if (parked_q && ctl_cont_i && !ctl_cont_start_i && ptr_mem_i) begin
                            // resume past the halted descriptor
                            if (dctl_q.linked) begin
                                ph_n = PH_LINK;
                            end else begin
                                op.adv_lin = 1'b1;
                                ph_n       = PH_SRC_FETCH;
                            end
                        end else begin
                            op.ld_start = 1'b1;
                            ph_n        = ptr_mem_i ? PH_DST_FETCH : PH_XFER;
                        end
                    end else if (parked_q && ctl_cont_i) begin
                        parked_n = 1'b0;
                    end
                end
            end
            PH_DST_FETCH: begin
                if (!dst_ok_i) begin
                    ph_n   = PH_IDLE;
                    err_n  = 1'b1;
                    errp_n = 1'b1;
                end else if (fetch_done_i) begin
                    ph_n = PH_SRC_FETCH;
                end
            end
            PH_SRC_FETCH: begin
                if (!src_ok_i) begin
                    ph_n   = PH_IDLE;
                    err_n  = 1'b1;
                    errp_n = 1'b1;
                end else if (fetch_done_i) begin
                    dctl_n = fetch_ctl_i;
                    ph_n   = PH_XFER;
                end
            end
            PH_XFER: begin
                if (xfer_done_i) begin
                    irq_n = mode_q ? dctl_q.intr : reg_intr_i;
                    if (!mode_q || dctl_q.cmd == CMD_STOP) begin
                        en_n = 1'b0;
                        ph_n = PH_IDLE;
                    end else if (dctl_q.cmd == CMD_HALT) begin
                        parked_n = 1'b1;
                        pause_n  = 1'b1;
                        ph_n     = PH_IDLE;
                    end else if (dctl_q.linked) begin
                        ph_n = PH_LINK;
                    end else begin
                        op.adv_lin = 1'b1;
                        ph_n       = PH_SRC_FETCH;
                    end
                end
            end
            PH_LINK: begin
                if (link_done_i) begin
                    op.ld_link = 1'b1;
                    ph_n       = PH_SRC_FETCH;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            parked_q <= 1'b0;
            err_q    <= 1'b0;
            en_q     <= 1'b0;
            mode_q   <= 1'b0;
            dctl_q   <= '0;
            pause_q  <= 1'b0;
            errp_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            ph_q     <= ph_n;
            parked_q <= parked_n;
            err_q    <= err_n;
            en_q     <= en_n;
            mode_q   <= mode_n;
            dctl_q   <= dctl_n;
            pause_q  <= pause_n;
            errp_q   <= errp_n;
            irq_q    <= irq_n;
        end
    end

    assign ph_o        = ph_q;
    assign parked_o    = parked_q;
    assign err_o       = err_q;
    assign en_o        = en_q;
    assign pause_evt_o = pause_q;
    assign err_evt_o   = errp_q;
    assign irq_evt_o   = irq_q;
    assign op_o        = op;

    // R6: a stop descriptor ends the run and drops enable
    p_stop_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_XFER && xfer_done_i && mode_q && dctl_q.cmd == CMD_STOP)
        |=> (ph_q == PH_IDLE && !en_q));

    // R7: a halt descriptor parks the channel with a pause event
    p_halt_parks_r7: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_XFER && xfer_done_i && mode_q && dctl_q.cmd == CMD_HALT)
        |=> (parked_q && pause_q && en_q && ph_q == PH_IDLE));

    // R5: register mode finishes after its single transfer
    p_reg_single_r5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_XFER && xfer_done_i && !mode_q) |=> (ph_q == PH_IDLE && !en_q));

    // R13: while busy, enable changes only through a completed transfer
    p_busy_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE && !(ph_q == PH_XFER && xfer_done_i)) |=> $stable(en_q));

endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
    import dma_run_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_i,
    input  logic              ctl_en_i,
    input  logic              ctl_cont_i,
    input  logic              ctl_cont_start_i,
    input  logic              ptr_mem_i,
    input  logic              reg_intr_i,
    input  logic [ADDR_W-1:0] src_start_i,
    input  logic [ADDR_W-1:0] dst_start_i,
    output logic              fetch_req_o,
    output logic              fetch_sel_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_done_i,
    input  logic [1:0]        fetch_cmd_i,
    input  logic              fetch_linked_i,
    input  logic              fetch_intr_i,
    output logic              xfer_req_o,
    input  logic              xfer_done_i,
    output logic              link_req_o,
    output logic [ADDR_W-1:0] link_addr_o,
    input  logic              link_done_i,
    input  logic [ADDR_W-1:0] link_ptr_i,
    output logic [1:0]        state_o,
    output logic              en_o,
    output logic [ADDR_W-1:0] src_ptr_o,
    output logic [ADDR_W-1:0] dst_ptr_o,
    output logic              pause_evt_o,
    output logic              err_evt_o,
    output logic              desc_irq_o
);
    phase_e            ph;
    logic              parked, err;
    ptr_op_t           op;
    desc_ctl_t         fetch_ctl;
    logic              src_ok, dst_ok;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;

    assign fetch_ctl = '{cmd: fetch_cmd_i, linked: fetch_linked_i, intr: fetch_intr_i};

    dma_run_seq u_seq (
        .clk              (clk),
        .rst              (rst),
        .ctl_wr_i         (ctl_wr_i),
        .ctl_en_i         (ctl_en_i),
        .ctl_cont_i       (ctl_cont_i),
        .ctl_cont_start_i (ctl_cont_start_i),
        .ptr_mem_i        (ptr_mem_i),
        .reg_intr_i       (reg_intr_i),
        .fetch_done_i     (fetch_done_i),
        .fetch_ctl_i      (fetch_ctl),
        .xfer_done_i      (xfer_done_i),
        .link_done_i      (link_done_i),
        .src_ok_i         (src_ok),
        .dst_ok_i         (dst_ok),
        .ph_o             (ph),
        .parked_o         (parked),
        .err_o            (err),
        .en_o             (en_o),
        .pause_evt_o      (pause_evt_o),
        .err_evt_o        (err_evt_o),
        .irq_evt_o        (desc_irq_o),
        .op_o             (op)
    );

    dma_ptr_regs #(
        .ADDR_W     (ADDR_W),
        .DESC_BYTES (DESC_BYTES)
    ) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .src_start_i (src_start_i),
        .dst_start_i (dst_start_i),
        .link_ptr_i  (link_ptr_i),
        .src_o       (src_ptr),
        .dst_o       (dst_ptr),
        .link_addr_o (link_addr_o),
        .src_ok_o    (src_ok),
        .dst_ok_o    (dst_ok)
    );

    assign fetch_sel_o  = (ph == PH_DST_FETCH);
    assign fetch_req_o  = (ph == PH_DST_FETCH && dst_ok) || (ph == PH_SRC_FETCH && src_ok);
    assign fetch_addr_o = fetch_sel_o ? dst_ptr : src_ptr;
    assign xfer_req_o   = (ph == PH_XFER);
    assign link_req_o   = (ph == PH_LINK);
    assign state_o      = report_state(ph, parked, err);
    assign src_ptr_o    = src_ptr;
    assign dst_ptr_o    = dst_ptr;

    // R4: requests are mutually exclusive
    p_one_req_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_req_o, xfer_req_o, link_req_o}));

    // R4: a transfer starts only after a source fetch or a register-mode start
    p_xfer_after_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_req_o) |->
            ($past(fetch_done_i && fetch_req_o && !fetch_sel_o) || $past(ctl_wr_i)));

    // R10: a running cycle with no request is a refused fetch and leads to fault
    p_bad_ptr_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && !fetch_req_o && !xfer_req_o && !link_req_o)
        |=> (state_o == 2'd3 && err_evt_o));

    // R2: fault and paused are never reported while a request is pending
    p_idle_no_req_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd1) |-> !(fetch_req_o || xfer_req_o || link_req_o));

endmodule

// File: tb/dma_run_ctrl_test.sv
module dma_run_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] SRC0 = 64'h1000;
    localparam logic [63:0] DST0 = 64'h2000;
    localparam logic [63:0] LNK0 = 64'h5000;

    typedef struct packed {
        logic [1:0]  cmd;
        logic        linked;
        logic        intr;
        logic [1:0]  st;
        logic [63:0] src;
        logic        en;
        logic [3:0]  nf;
        logic [3:0]  nirq;
        logic [3:0]  npause;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 1'b0, 1'b1, 2'd0, 64'h1000, 1'b0, 4'd2, 4'd1, 4'd0},
        '{2'd1, 1'b0, 1'b0, 2'd2, 64'h1000, 1'b1, 4'd2, 4'd0, 4'd1},
        '{2'd0, 1'b0, 1'b1, 2'd0, 64'h1010, 1'b0, 4'd3, 4'd1, 4'd0},
        '{2'd0, 1'b1, 1'b0, 2'd0, 64'h5000, 1'b0, 4'd3, 4'd0, 4'd0},
        '{2'd3, 1'b0, 1'b1, 2'd0, 64'h1010, 1'b0, 4'd3, 4'd1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr_i = 0, ctl_en_i = 0, ctl_cont_i = 0, ctl_cont_start_i = 0;
    logic        ptr_mem_i = 1, reg_intr_i = 0;
    logic [63:0] src_start_i = SRC0, dst_start_i = DST0;
    logic        fetch_req_o, fetch_sel_o;
    logic [63:0] fetch_addr_o;
    logic        fetch_done_i = 0;
    logic [1:0]  fetch_cmd_i = 0;
    logic        fetch_linked_i = 0, fetch_intr_i = 0;
    logic        xfer_req_o;
    logic        xfer_done_i = 0;
    logic        link_req_o;
    logic [63:0] link_addr_o;
    logic        link_done_i = 0;
    logic [63:0] link_ptr_i = LNK0;
    logic [1:0]  state_o;
    logic        en_o;
    logic [63:0] src_ptr_o, dst_ptr_o;
    logic        pause_evt_o, err_evt_o, desc_irq_o;

    dma_run_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    // responder state and logs
    logic [1:0]  first_cmd = 0;
    logic        first_linked = 0, first_intr = 0;
    bit          hold_xfer = 0;
    int          n_fetch, n_src, n_xfer, n_pause, n_err, n_irq;
    logic        f_sel [8];
    logic [63:0] f_addr [8];
    logic [63:0] last_link;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic clear_logs();
        n_fetch = 0; n_src = 0; n_xfer = 0; n_pause = 0; n_err = 0; n_irq = 0;
        last_link = '0;
        for (int i = 0; i < 8; i++) begin f_sel[i] = 0; f_addr[i] = '0; end
    endtask

    task automatic step();
        @(negedge clk);
        if (pause_evt_o) n_pause++;
        if (err_evt_o)   n_err++;
        if (desc_irq_o)  n_irq++;
        fetch_done_i = 0; xfer_done_i = 0; link_done_i = 0;
        if (fetch_req_o) begin
            if (n_fetch < 8) begin f_sel[n_fetch] = fetch_sel_o; f_addr[n_fetch] = fetch_addr_o; end
            n_fetch++;
            fetch_done_i = 1;
            if (!fetch_sel_o) begin
                if (n_src == 0) begin
                    fetch_cmd_i = first_cmd; fetch_linked_i = first_linked; fetch_intr_i = first_intr;
                end else begin
                    fetch_cmd_i = 2'd2; fetch_linked_i = 0; fetch_intr_i = 0;
                end
                n_src++;
            end else begin
                fetch_cmd_i = 0; fetch_linked_i = 0; fetch_intr_i = 0;
            end
        end
        if (xfer_req_o && !hold_xfer) begin n_xfer++; xfer_done_i = 1; end
        if (link_req_o) begin last_link = link_addr_o; link_done_i = 1; end
    endtask

    task automatic ctl(input logic en, input logic cont, input logic cs);
        ctl_en_i = en; ctl_cont_i = cont; ctl_cont_start_i = cs; ctl_wr_i = 1;
        step();
        ctl_wr_i = 0; ctl_en_i = 0; ctl_cont_i = 0; ctl_cont_start_i = 0;
    endtask

    task automatic run();
        for (int i = 0; i < 200 && state_o == 2'd1; i++) step();
    endtask

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic go(input logic [1:0] cmd, input logic lk, input logic ir);
        first_cmd = cmd; first_linked = lk; first_intr = ir;
        clear_logs();
        ctl(1, 0, 0);
        run();
    endtask

    initial begin
        clear_logs();
        repeat (3) step();
        rst = 0;
        step();
        // R1: reset condition
        check("R1", "state", state_o, 0);
        check("R1", "en", en_o, 0);
        check("R1", "reqs", {fetch_req_o, xfer_req_o, link_req_o}, 0);
        check("R1", "src ptr", src_ptr_o, 0);

        // Table walk: R6 R7 R8 R9 R14
        for (int v = 0; v < NV; v++) begin
            go(TBL[v].cmd, TBL[v].linked, TBL[v].intr);
            check("R6/R7 (R2)", $sformatf("vec%0d state", v), state_o, TBL[v].st);
            check("R8/R9", $sformatf("vec%0d src ptr", v), src_ptr_o, TBL[v].src);
            check("R6", $sformatf("vec%0d en", v), en_o, TBL[v].en);
            check("R3", $sformatf("vec%0d fetches", v), n_fetch, TBL[v].nf);
            check("R14", $sformatf("vec%0d irq", v), n_irq, TBL[v].nirq);
            check("R7", $sformatf("vec%0d pause", v), n_pause, TBL[v].npause);
        end
        // R9: link read address of the linked vector is source plus 16
        go(2'd0, 1'b1, 1'b0);
        check("R9", "link addr", last_link, 64'h1010);
        check("R9", "second fetch addr", f_addr[1 + 1], LNK0);

        // R3: fetch order after a start
        go(2'd2, 1'b0, 1'b0);
        check("R3", "first fetch sel", f_sel[0], 1);
        check("R3", "first fetch addr", f_addr[0], DST0);
        check("R3", "second fetch sel", f_sel[1], 0);
        check("R3", "second fetch addr", f_addr[1], SRC0);
        check("R3", "dst ptr", dst_ptr_o, DST0);

        // R4 + R13: stall the transfer; write during busy is ignored
        hold_xfer = 1;
        first_cmd = 2'd2; first_linked = 0; first_intr = 0;
        clear_logs();
        ctl(1, 0, 0);
        repeat (4) step();
        check("R4", "running while transfer pending", state_o, 1);
        check("R4", "xfer req after src fetch", xfer_req_o, 1);
        check("R4", "fetches before xfer", n_fetch, 2);
        ctl(0, 1, 0);
        step();
        check("R13", "en kept", en_o, 1);
        check("R13", "state kept", state_o, 1);
        hold_xfer = 0;
        run();
        check("R6", "state after stop", state_o, 0);

        // R5 + R14: register mode
        ptr_mem_i = 0; reg_intr_i = 1;
        hold_xfer = 1;
        clear_logs();
        ctl(1, 0, 0);
        step();
        check("R2", "running state code", state_o, 1);
        hold_xfer = 0;
        run();
        check("R5", "no fetch", n_fetch, 0);
        check("R5", "one xfer", n_xfer, 1);
        check("R5", "en cleared", en_o, 0);
        check("R5", "state", state_o, 0);
        check("R14", "reg irq", n_irq, 1);
        ptr_mem_i = 1; reg_intr_i = 0;

        // R11: resume past halted linear descriptor
        go(2'd1, 1'b0, 1'b0);
        first_cmd = 2'd2; first_linked = 0; first_intr = 0;
        clear_logs();
        ctl(1, 1, 0);
        run();
        check("R11", "resume lin fetch count", n_fetch, 1);
        check("R11", "resume lin fetch addr", f_addr[0], 64'h1010);
        check("R11", "resume lin state", state_o, 0);

        // R11: resume past halted linked descriptor
        go(2'd1, 1'b1, 1'b0);
        first_cmd = 2'd2; first_linked = 0; first_intr = 0;
        clear_logs();
        ctl(1, 1, 0);
        run();
        check("R11", "resume link read addr", last_link, 64'h1010);
        check("R11", "resume link fetch addr", f_addr[0], LNK0);
        check("R11", "resume link src ptr", src_ptr_o, LNK0);

        // R11: resume from start addresses
        go(2'd1, 1'b0, 1'b0);
        first_cmd = 2'd2; first_linked = 0; first_intr = 0;
        clear_logs();
        ctl(1, 1, 1);
        run();
        check("R11", "restart fetches", n_fetch, 2);
        check("R11", "restart first is dst", f_sel[0], 1);
        check("R11", "restart src addr", f_addr[1], SRC0);

        // R12: clearing enable while paused
        go(2'd1, 1'b0, 1'b0);
        ctl(0, 0, 0);
        check("R12", "cont=0 stays paused", state_o, 2);
        check("R12", "en cleared", en_o, 0);
        ctl(0, 1, 0);
        check("R12", "cont=1 disables", state_o, 0);

        // R10: misaligned source pointer
        src_start_i = 64'h1008;
        clear_logs();
        ctl(1, 0, 0);
        run();
        check("R10", "fault state", state_o, 3);
        check("R10", "only dst fetched", n_fetch, 1);
        check("R10", "err pulse", n_err, 1);
        repeat (3) step();
        check("R10", "fault holds", state_o, 3);
        // R10: misaligned destination pointer
        src_start_i = SRC0; dst_start_i = 64'h2004;
        clear_logs();
        ctl(1, 0, 0);
        run();
        check("R10", "dst fault state", state_o, 3);
        check("R10", "no fetch", n_fetch, 0);
        // R3: enabling again clears the error
        dst_start_i = DST0;
        go(2'd2, 1'b0, 1'b0);
        check("R3", "error cleared", state_o, 0);
        check("R3", "fetches after clear", n_fetch, 2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule